// File: doc/BRIEF.md
# Reset and Watchdog Controller

This block sequences reset for a small microcontroller system. An external active-high reset pin, or an overflow of a fixed-period hardware watchdog, places the core in reset. Once the cause clears, the block counts a fixed number of slow crystal-clock ticks and then releases the core with a one-cycle boot pulse, so the CPU starts fetching at address zero. The crystal tick arrives as a single-cycle strobe in the fast clock domain.

The two reset paths differ in what they clear. A pin reset also drives a register-file reset that returns the memory-mapped control registers to their defaults. A watchdog reset leaves those registers untouched. Firmware refreshes the watchdog through a strobe. The watchdog can be switched off only by hardware: a debug-enable input, or a detect input that reports the power-fault sense line tied to the digital supply. A sticky flag tells boot code which path caused the last reset. The real-time clock is never reset by this block.

With the default parameters the wait is 4096 ticks (125 ms at 32768 Hz) and the watchdog limit is 49152 ticks (1.5 s).

Top module: `rst_wdog_ctrl`

## Requirements
- R1: While `rstPin` is high, on every clock edge after the first one that samples it high, `coreRst` and `regRst` are 1, `bootStart` is 0 and `wdCause` is 0.
- R2: After `rstPin` falls, `coreRst` stays 1 through the first RST_CYCLES-1 ticks of `xtalTick` and goes to 0 at the edge that samples the RST_CYCLES-th tick. Ticks seen while the pin is high, and in the cycle that first samples it low, are not counted.
- R3: `bootStart` is 1 for exactly one cycle: the cycle in which `coreRst` first reads 0 after a reset. It is 0 at every other time.
- R4: While the core runs and the watchdog is enabled, each tick advances the watchdog. With no refresh, the WD_LIMIT-th tick since the last clear raises `coreRst` at the edge that samples it.
- R5: A `wdRefresh` strobe clears the watchdog count. If a refresh and a tick arrive in the same cycle, the refresh wins and the count is zero.
- R6: A watchdog reset keeps `regRst` at 0 for its whole duration. It waits RST_CYCLES ticks and then releases the core with `bootStart`, as R2 and R3 describe.
- R7: While `dbgEn` or `supplyTie` is 1, the watchdog count is held at zero and no overflow occurs. When both inputs return to 0, a full WD_LIMIT ticks are needed to reach an overflow. No other input disables the watchdog.
- R8: `wdCause` becomes 1 on a watchdog overflow. It stays 1 through the reset wait, through boot and through later watchdog resets. Only a pin reset returns it to 0.
- R9: A pin reset during the wait that follows a watchdog overflow asserts `regRst` and clears `wdCause`. After the pin is released, the full RST_CYCLES-tick wait starts again.
- R10: The watchdog does not count while the core is in reset. After every boot it starts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rstPin | input | 1 | External reset pin, active high, synchronous to clk |
| xtalTick | input | 1 | One-cycle strobe for each crystal clock period |
| wdRefresh | input | 1 | Watchdog refresh strobe from firmware |
| dbgEn | input | 1 | Debug enable; 1 turns the watchdog off |
| supplyTie | input | 1 | 1 when the power-fault sense line is tied to the digital supply; turns the watchdog off |
| coreRst | output | 1 | Holds the CPU and digital logic in reset, active high |
| regRst | output | 1 | Returns the control registers to their defaults, active high; asserted only for a pin reset |
| bootStart | output | 1 | One-cycle pulse that starts the CPU at address zero |
| wdCause | output | 1 | Sticky reset cause: 1 = watchdog, 0 = pin |

## Verification
The bench sweeps the refresh point across every tick position inside the watchdog period, and it inserts idle cycles of several lengths between ticks. A counter that is off by one would move the overflow edge or the release edge, and the bench checks that exact edge. A refresh arriving together with a tick, and ticks arriving while the pin is still high, expose a design that lets the tick win or that counts during the pin hold. The bench also aborts a watchdog wait with the pin and expects a full restart with the registers cleared. A design that kept the old count, left `regRst` low or kept the watchdog cause would fail those checks. Debug and supply-tie holds run for several watchdog periods to show that they hold the count at zero rather than just pausing it.

// File: rtl/rwc_pkg.sv
package rwc_pkg;

  typedef enum logic [1:0] {
    ST_PINHOLD = 2'd0,
    ST_WAIT    = 2'd1,
    ST_RUN     = 2'd2
  } rwc_state_e;

  typedef struct packed {
    logic rstClr;
    logic rstInc;
    logic wdClr;
    logic wdInc;
  } rwc_strobe_t;

endpackage

// File: rtl/rwc_datapath.sv
module rwc_datapath #(
  parameter int RST_CYCLES = 4096,
  parameter int WD_LIMIT   = 49152
) (
  input  logic                      clk,
  input  logic                      rstPin,
  input  rwc_pkg::rwc_strobe_t      strobe,
  output logic                      rstLast,
  output logic                      wdLast,
  output logic [$clog2(WD_LIMIT)-1:0] wdCountOut
);
  localparam int RW = $clog2(RST_CYCLES);
  localparam int WW = $clog2(WD_LIMIT);
  localparam logic [RW-1:0] RST_END = RW'(RST_CYCLES - 1);
  localparam logic [WW-1:0] WD_END  = WW'(WD_LIMIT - 1);

  logic [RW-1:0] rstCount;
  logic [WW-1:0] wdCount;

  always_ff @(posedge clk) begin
    if (rstPin) begin
      rstCount <= '0;
    end else if (strobe.rstClr) begin
      rstCount <= '0;
    end else if (strobe.rstInc) begin
      rstCount <= rstCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rstPin) begin
      wdCount <= '0;
    end else if (strobe.wdClr) begin
      wdCount <= '0;
    end else if (strobe.wdInc) begin
      wdCount <= wdCount + 1'b1;
    end
  end

  assign rstLast    = (rstCount == RST_END);
  assign wdLast     = (wdCount == WD_END);
  assign wdCountOut = wdCount;

  // R2: the reset wait counter never passes its last value
  a_r2_timer_bound: assert property (@(posedge clk) disable iff (rstPin)
    rstCount <= RST_END);
  // R4: the watchdog counter never passes its overflow value
  a_r4_wd_bound: assert property (@(posedge clk) disable iff (rstPin)
    wdCount <= WD_END);
  // R5: a clear strobe always lands the counter on zero
  a_r5_clear_wins: assert property (@(posedge clk) disable iff (rstPin)
    strobe.wdClr |=> wdCount == '0);

endmodule

// File: rtl/rwc_control.sv
module rwc_control (
  input  logic                 clk,
  input  logic                 rstPin,
  input  logic                 xtalTick,
  input  logic                 wdRefresh,
  input  logic                 dbgEn,
  input  logic                 supplyTie,
  input  logic                 rstLast,
  input  logic                 wdLast,
  output rwc_pkg::rwc_strobe_t strobe,
  output logic                 coreRst,
  output logic                 regRst,
  output logic                 bootStart,
  output logic                 wdCause
);
  import rwc_pkg::*;

  rwc_state_e state;
  logic       fromPin;
  logic       wdOn;
  logic       overflow;
  logic       waitDone;

  assign wdOn     = !dbgEn && !supplyTie;
  assign waitDone = (state == ST_WAIT) && xtalTick && rstLast;
  assign overflow = (state == ST_RUN) && wdOn && xtalTick && !wdRefresh && wdLast;

  always_ff @(posedge clk) begin
    if (rstPin) begin
      state     <= ST_PINHOLD;
      fromPin   <= 1'b1;
      wdCause   <= 1'b0;
      bootStart <= 1'b0;
    end else begin
      bootStart <= 1'b0;
      unique case (state)
        ST_PINHOLD: state <= ST_WAIT;
        ST_WAIT: begin
          if (waitDone) begin
            state     <= ST_RUN;
            bootStart <= 1'b1;
          end
        end
        ST_RUN: begin
          if (overflow) begin
            state   <= ST_WAIT;
            fromPin <= 1'b0;
            wdCause <= 1'b1;
          end
        end
        default: state <= ST_PINHOLD;
      endcase
    end
  end

  always_comb begin
    strobe.rstClr = (state != ST_WAIT);
    strobe.rstInc = (state == ST_WAIT) && xtalTick && !rstLast;
    strobe.wdClr  = (state != ST_RUN) || !wdOn || wdRefresh || overflow;
    strobe.wdInc  = xtalTick;
  end

  assign coreRst = (state != ST_RUN);
  assign regRst  = (state == ST_PINHOLD) || ((state == ST_WAIT) && fromPin);

  // R3: the boot pulse lasts a single cycle
  a_r3_boot_single: assert property (@(posedge clk) disable iff (rstPin)
    bootStart |=> !bootStart);
  // R3: the boot pulse coincides with the core leaving reset
  a_r3_boot_release: assert property (@(posedge clk) disable iff (rstPin)
    bootStart |-> (!coreRst && $past(coreRst)));
  // R6: a reset entered without the pin leaves the registers alone
  a_r6_wd_keeps_regs: assert property (@(posedge clk) disable iff (rstPin)
    ($rose(coreRst) && !$past(rstPin)) |-> !regRst);
  // R8: the watchdog cause flag only falls under the pin
  a_r8_cause_sticky: assert property (@(posedge clk) disable iff (rstPin)
    wdCause |=> wdCause);

endmodule

// File: rtl/rst_wdog_ctrl.sv
module rst_wdog_ctrl #(
  parameter int RST_CYCLES = 4096,
  parameter int WD_LIMIT   = 49152
) (
  input  logic clk,
  input  logic rstPin,
  input  logic xtalTick,
  input  logic wdRefresh,
  input  logic dbgEn,
  input  logic supplyTie,
  output logic coreRst,
  output logic regRst,
  output logic bootStart,
  output logic wdCause
);
  localparam int WW = $clog2(WD_LIMIT);

  rwc_pkg::rwc_strobe_t strobe;
  logic                 rstLast;
  logic                 wdLast;
  logic [WW-1:0]        wdCount;

  rwc_control u_ctrl (
    .clk       (clk),
    .rstPin    (rstPin),
    .xtalTick  (xtalTick),
    .wdRefresh (wdRefresh),
    .dbgEn     (dbgEn),
    .supplyTie (supplyTie),
    .rstLast   (rstLast),
    .wdLast    (wdLast),
    .strobe    (strobe),
    .coreRst   (coreRst),
    .regRst    (regRst),
    .bootStart (bootStart),
    .wdCause   (wdCause)
  );

  rwc_datapath #(
    .RST_CYCLES (RST_CYCLES),
    .WD_LIMIT   (WD_LIMIT)
  ) u_dp (
    .clk        (clk),
    .rstPin     (rstPin),
    .strobe     (strobe),
    .rstLast    (rstLast),
    .wdLast     (wdLast),
    .wdCountOut (wdCount)
  );

  // R7: either hardware disable input holds the watchdog at zero
  a_r7_wd_held: assert property (@(posedge clk) disable iff (rstPin)
    (dbgEn || supplyTie) |=> wdCount == '0);
  // R10: the watchdog sits at zero while the core is held
  a_r10_idle_in_reset: assert property (@(posedge clk) disable iff (rstPin)
    coreRst |=> wdCount == '0);

endmodule

// File: tb/sim_rst_wdog_ctrl.sv
module sim_rst_wdog_ctrl;
  localparam int RST_T = 12;
  localparam int WD_T  = 30;

  logic clk = 1'b0;
  logic rstPin = 1'b1;
  logic xtalTick = 1'b0;
  logic wdRefresh = 1'b0;
  logic dbgEn = 1'b0;
  logic supplyTie = 1'b0;
  logic coreRst, regRst, bootStart, wdCause;

  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  rst_wdog_ctrl #(.RST_CYCLES(RST_T), .WD_LIMIT(WD_T)) u0 (
    .clk(clk), .rstPin(rstPin), .xtalTick(xtalTick), .wdRefresh(wdRefresh),
    .dbgEn(dbgEn), .supplyTie(supplyTie), .coreRst(coreRst), .regRst(regRst),
    .bootStart(bootStart), .wdCause(wdCause)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock: inputs set after a falling edge, outputs read at the next one
  task automatic step(input logic t, input logic r);
    xtalTick = t;
    wdRefresh = r;
    @(negedge clk);
    xtalTick = 1'b0;
    wdRefresh = 1'b0;
  endtask

  // n ticks, each after gap idle cycles; returns cycles with the core out of reset or a boot pulse
  task automatic ticksWatch(input int n, input int gap, output int leaks);
    leaks = 0;
    for (int i = 0; i < n; i++) begin
      for (int g = 0; g < gap; g++) begin
        step(1'b0, 1'b0);
        if (!coreRst || bootStart) leaks++;
      end
      step(1'b1, 1'b0);
      if (!coreRst || bootStart) leaks++;
    end
  endtask

  // n running ticks, no refresh; returns cycles in which the core entered reset
  task automatic runTicks(input int n, input int gap, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      for (int g = 0; g < gap; g++) begin
        step(1'b0, 1'b0);
        if (coreRst) hits++;
      end
      step(1'b1, 1'b0);
      if (coreRst) hits++;
    end
  endtask

  task automatic finishWait(input string req, input int gap);
    int leaks;
    ticksWatch(RST_T - 1, gap, leaks);
    chk({req, " core held before last tick"}, leaks, 0);
    for (int g = 0; g < gap; g++) step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    chk({req, " core released on last tick"}, coreRst, 0);
    chk({req, " boot pulse with release"}, bootStart, 1);
    step(1'b0, 1'b0);
    chk({req, " boot pulse one cycle"}, bootStart, 0);
  endtask

  task automatic pinBoot(input int gap);
    rstPin = 1'b1;
    step(1'b0, 1'b0);
    rstPin = 1'b0;
    step(1'b0, 1'b0);
    finishWait("R2/R3", gap);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog R1-all: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int hits;
    int leaks;
    @(negedge clk);
    // R1: pin held, ticks during the hold must not count
    for (int i = 0; i < 40; i++) begin
      step(1'b1, 1'b1);
      if (i == 5) begin
        chk("R1 coreRst", coreRst, 1);
        chk("R1 regRst", regRst, 1);
        chk("R1 bootStart", bootStart, 0);
        chk("R1 wdCause", wdCause, 0);
      end
    end
    rstPin = 1'b0;
    step(1'b0, 1'b0);
    chk("R1 regRst during pin wait", regRst, 1);
    finishWait("R2 ticks under pin ignored", 0);
    chk("R2 regRst after boot", regRst, 0);

    // R4/R10/R6: overflow edge for several tick spacings
    for (int gap = 0; gap < 3; gap++) begin
      runTicks(WD_T - 1, gap, hits);
      chk("R4 no reset before limit", hits, 0);
      step(1'b1, 1'b0);
      chk("R4 reset on limit tick", coreRst, 1);
      chk("R6 regRst kept low", regRst, 0);
      chk("R8 cause set", wdCause, 1);
      finishWait("R6 watchdog wait", gap);
      chk("R8 cause kept after boot", wdCause, 1);
      chk("R6 regRst low at boot", regRst, 0);
    end

    // R5: refresh at every tick position keeps the core running
    for (int k = 1; k < WD_T; k++) begin
      runTicks(k, 0, hits);
      step(1'b0, 1'b1);
      chk("R5 refresh sweep", hits + coreRst, 0);
    end
    // R5: refresh wins over a simultaneous tick
    runTicks(WD_T - 2, 0, hits);
    step(1'b1, 1'b1);
    runTicks(WD_T - 1, 0, hits);
    chk("R5 refresh beats tick", hits, 0);
    step(1'b1, 1'b0);
    chk("R5 overflow after refresh+tick", coreRst, 1);
    finishWait("R6 second wait", 1);

    // R7: debug enable and supply tie hold the watchdog at zero
    for (int mode = 0; mode < 2; mode++) begin
      runTicks(WD_T - 1, 0, hits);
      if (mode == 0) dbgEn = 1'b1; else supplyTie = 1'b1;
      runTicks(3 * WD_T, 0, hits);
      chk("R7 no overflow while disabled", hits, 0);
      dbgEn = 1'b0;
      supplyTie = 1'b0;
      step(1'b0, 1'b0);
      runTicks(WD_T - 1, 0, hits);
      chk("R7 count restarted from zero", hits, 0);
      step(1'b1, 1'b0);
      chk("R7 overflow after re-enable", coreRst, 1);
      finishWait("R7 wait", 0);
    end

    // R9: pin during the watchdog wait
    runTicks(WD_T, 0, hits);
    chk("R9 overflow reached", coreRst, 1);
    ticksWatch(RST_T - 3, 0, leaks);
    chk("R9 regRst low in wd wait", regRst, 0);
    rstPin = 1'b1;
    step(1'b1, 1'b0);
    chk("R9 regRst on pin", regRst, 1);
    chk("R9 cause cleared", wdCause, 0);
    rstPin = 1'b0;
    step(1'b0, 1'b0);
    chk("R9 regRst in restarted wait", regRst, 1);
    finishWait("R9 full restart", 0);

    // R8: only the pin clears the cause; a pin reset in run clears it
    runTicks(WD_T, 0, hits);
    finishWait("R8 wd boot", 0);
    runTicks(WD_T, 0, hits);
    chk("R8 second wd reset keeps cause", wdCause, 1);
    finishWait("R8 wd boot 2", 2);
    pinBoot(1);
    chk("R8 pin clears cause", wdCause, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule